// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block is a small direct-mapped table that predicts the direction and destination of conditional branches. The decode stage presents the address of a branch instruction on the lookup port. One cycle later the block reports whether the address is in the table, whether the branch is predicted taken, and the next fetch address that the instruction prefetcher should use when the prediction is taken.

The execute stage reports each resolved branch on the update port. It gives the branch address, the actual direction and the actual destination. A branch gets an entry only when it is first taken. From then on a two-bit saturating history counter is trained by every resolution. The block also compares each resolution against the prediction the table would give for that branch, and flags a disagreement with a one-cycle pulse. Flushing and refetching are left to the surrounding pipeline.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous active-high reset invalidates every entry. In the cycle after reset is released, `pred_hit`, `pred_taken`, `mispredict` and `pred_target` are all 0.
- R2: The lookup result is registered and appears one cycle after `lk_valid` is sampled. In these cases `pred_hit`, `pred_taken` and `pred_target` are all 0 in that next cycle: a cycle with `lk_valid` low, or a lookup that misses.
- R3: The entry index is `pc[OFFSET_W +: IDX_W]`, where IDX_W = log2(ENTRIES). The bits above the index form a tag, stored with a valid bit. A lookup hits only when the entry is valid and the tag matches, so another address that shares the index misses.
- R4: A taken resolution that misses writes a fresh entry at its index, replacing any other tag there. The entry holds the tag, the resolved destination and history 2'b11. A not-taken resolution that misses leaves the table unchanged.
- R5: On a hit, the prediction is taken exactly when the history is nonzero. `pred_target` carries the stored destination when the prediction is taken, and 0 otherwise.
- R6: A resolution that hits moves the history up by one when taken and down by one when not taken. The history saturates at 2'b11 and 2'b00 and never wraps.
- R7: A taken resolution that hits replaces the stored destination with the resolved destination.
- R8: One cycle after an update, `mispredict` is 1 in either case below, and it is 0 in every cycle not preceded by an update. The first case is a resolved direction that differs from the table's prediction, where a miss counts as not taken. The second is a taken branch predicted taken whose stored destination differs from the resolved one.
- R9: When a lookup and an update arrive in the same cycle, both the lookup result and the mispredict decision use the table contents from before that update.
- R10: A branch whose history has fallen to 2'b00 and that then alternates taken and not taken is mispredicted on every resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | ADDR_W | Address of the branch being looked up |
| upd_valid | input | 1 | Resolved branch reported this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction (1 = taken) |
| upd_target | input | ADDR_W | Actual destination of the resolved branch |
| pred_hit | output | 1 | Lookup of the previous cycle found a valid matching entry |
| pred_taken | output | 1 | Lookup of the previous cycle predicts taken |
| pred_target | output | ADDR_W | Next fetch address when predicted taken, else 0 |
| mispredict | output | 1 | One-cycle pulse: the previous cycle's resolution contradicted the table |

## Verification
Every result of this block arrives exactly one clock edge after its stimulus. A lookup presented before an edge shows its hit, direction and target after that edge. An update changes the table at the same edge, so a lookup one cycle later sees the trained entry, and its mispredict pulse also shows after that edge. The bench drives each cycle's inputs on a falling edge and records the expected outputs with a due cycle of one more than the current cycle. The monitor compares them on the next falling edge. Idle cycles are scored too, so a late, early or lingering output is caught as well as a wrong one.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef logic [1:0] hist_t;

    localparam hist_t HIST_ALLOC = 2'b11;
    localparam hist_t HIST_MAX   = 2'b11;
    localparam hist_t HIST_MIN   = 2'b00;

    function automatic hist_t hist_up(input hist_t h);
        return (h == HIST_MAX) ? h : h + 2'd1;
    endfunction

    function automatic hist_t hist_down(input hist_t h);
        return (h == HIST_MIN) ? h : h - 2'd1;
    endfunction

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 4,
    parameter int OFFSET_W = 2,
    localparam int TAG_W   = ADDR_W - IDX_W - OFFSET_W
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    logic [ADDR_W-1:0] word_addr;

    always_comb begin
        word_addr = pc >> OFFSET_W;
        idx       = IDX_W'(word_addr);
        tag       = TAG_W'(word_addr >> IDX_W);
    end
endmodule

// File: rtl/btb_entry_match.sv
module btb_entry_match
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 26
) (
    input  logic              ent_valid,
    input  logic [TAG_W-1:0]  ent_tag,
    input  hist_t             ent_hist,
    input  logic [TAG_W-1:0]  query_tag,
    output logic              hit,
    output logic              taken
);
    always_comb begin
        hit   = ent_valid && (ent_tag == query_tag);
        taken = hit && (ent_hist != HIST_MIN);
    end
endmodule

// File: rtl/btb_train.sv
module btb_train
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              was_hit,
    input  logic              was_taken,
    input  hist_t             old_hist,
    input  logic [ADDR_W-1:0] old_target,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target,
    output logic              write_en,
    output logic              target_we,
    output hist_t             new_hist,
    output logic              wrong
);
    always_comb begin
        write_en  = 1'b0;
        target_we = 1'b0;
        new_hist  = old_hist;
        if (was_hit) begin
            write_en  = 1'b1;
            target_we = res_taken;
            new_hist  = res_taken ? hist_up(old_hist) : hist_down(old_hist);
        end else if (res_taken) begin
            write_en  = 1'b1;
            target_we = 1'b1;
            new_hist  = HIST_ALLOC;
        end
        wrong = (res_taken != was_taken) ||
                (res_taken && was_taken && (old_target != res_target));
    end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int ENTRIES  = 16,
    parameter int OFFSET_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target,
    output logic              pred_hit,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target,
    output logic              mispredict
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W - OFFSET_W;

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][ADDR_W-1:0] tgt;
        logic [ENTRIES-1:0][1:0]        hist;
        logic                           o_hit;
        logic                           o_taken;
        logic [ADDR_W-1:0]              o_target;
        logic                           o_mis;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             lk_hit, lk_taken;
    logic             up_hit, up_pred;
    logic             wr_en, tgt_we, wrong;
    hist_t            wr_hist;

    btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFFSET_W(OFFSET_W)) u_split_lk (
        .pc(lk_pc), .idx(lk_idx), .tag(lk_tag)
    );

    btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFFSET_W(OFFSET_W)) u_split_up (
        .pc(upd_pc), .idx(up_idx), .tag(up_tag)
    );

    btb_entry_match #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_match_lk (
        .ent_valid (st_q.vld[lk_idx]),
        .ent_tag   (st_q.tag[lk_idx]),
        .ent_hist  (st_q.hist[lk_idx]),
        .query_tag (lk_tag),
        .hit       (lk_hit),
        .taken     (lk_taken)
    );

    btb_entry_match #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_match_up (
        .ent_valid (st_q.vld[up_idx]),
        .ent_tag   (st_q.tag[up_idx]),
        .ent_hist  (st_q.hist[up_idx]),
        .query_tag (up_tag),
        .hit       (up_hit),
        .taken     (up_pred)
    );

    btb_train #(.ADDR_W(ADDR_W)) u_train (
        .was_hit    (up_hit),
        .was_taken  (up_pred),
        .old_hist   (st_q.hist[up_idx]),
        .old_target (st_q.tgt[up_idx]),
        .res_taken  (upd_taken),
        .res_target (upd_target),
        .write_en   (wr_en),
        .target_we  (tgt_we),
        .new_hist   (wr_hist),
        .wrong      (wrong)
    );

    always_comb begin
        st_d          = st_q;
        st_d.o_hit    = lk_valid && lk_hit;
        st_d.o_taken  = lk_valid && lk_taken;
        st_d.o_target = (lk_valid && lk_taken) ? st_q.tgt[lk_idx] : '0;
        st_d.o_mis    = upd_valid && wrong;
        if (upd_valid && wr_en) begin
            st_d.vld[up_idx]  = 1'b1;
            st_d.tag[up_idx]  = up_tag;
            st_d.hist[up_idx] = wr_hist;
            if (tgt_we) begin
                st_d.tgt[up_idx] = upd_target;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pred_hit    = st_q.o_hit;
    assign pred_taken  = st_q.o_taken;
    assign pred_target = st_q.o_target;
    assign mispredict  = st_q.o_mis;

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_pc,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_pc,
    input logic              upd_taken,
    input logic [ADDR_W-1:0] upd_target,
    input logic              pred_hit,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] pred_target,
    input logic              mispredict
);
    // R1: outputs are quiet in the first cycle out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!pred_hit && !pred_taken && !mispredict && pred_target == '0));

    // R2: no lookup means no hit in the next cycle
    a_r2_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !pred_hit);

    // R5: a taken prediction needs a hit
    a_r5_taken_needs_hit: assert property (@(posedge clk) disable iff (rst)
        pred_taken |-> pred_hit);

    // R5: the fetch address is zero unless predicted taken
    a_r5_target_gated: assert property (@(posedge clk) disable iff (rst)
        !pred_taken |-> (pred_target == '0));

    // R8: a pulse only follows an update
    a_r8_pulse_needs_update: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> !mispredict);

    // R4: a taken resolution is found, taken, on the next lookup of that address
    a_r4_alloc_then_hit: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken) ##1 (lk_valid && !upd_valid && lk_pc == $past(upd_pc))
        |=> (pred_hit && pred_taken && pred_target == $past(upd_target, 2)));
endmodule

bind btb_predictor btb_predictor_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target),
    .pred_hit(pred_hit), .pred_taken(pred_taken),
    .pred_target(pred_target), .mispredict(mispredict)
);

// File: tb/btb_predictor_tb_top.sv
module btb_predictor_tb_top;
    localparam int AW = 32;
    localparam int N  = 16;
    localparam int OW = 2;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_pc = '0;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic [AW-1:0] upd_target = '0;
    logic          pred_hit, pred_taken, mispredict;
    logic [AW-1:0] pred_target;

    btb_predictor #(.ADDR_W(AW), .ENTRIES(N), .OFFSET_W(OW)) dut_i (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_pc(lk_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_target(upd_target),
        .pred_hit(pred_hit), .pred_taken(pred_taken),
        .pred_target(pred_target), .mispredict(mispredict)
    );

    always #10 clk = ~clk;

    int cyc   = 0;
    int total = 0;
    int bad   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // reference table built from the requirements
    logic          m_vld [N];
    logic [AW-1:0] m_tag [N];
    logic [AW-1:0] m_tgt [N];
    int            m_hist[N];

    // scoreboard queues: {hit, taken, mis, target}
    int            q_due[$];
    logic [AW+2:0] q_val[$];
    string         q_req[$];

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_hist[i] = 0;
        end
    endtask

    task automatic step(input logic lv, input logic [AW-1:0] lpc,
                        input logic uv, input logic [AW-1:0] upc,
                        input logic ut, input logic [AW-1:0] utg, input string req);
        int li, ui;
        logic eh, et, em, uh, up;
        logic [AW-1:0] eg;
        @(negedge clk);
        lk_valid = lv; lk_pc = lpc; upd_valid = uv; upd_pc = upc;
        upd_taken = ut; upd_target = utg;
        li = int'(lpc[OW +: IW]);
        eh = lv && m_vld[li] && (m_tag[li] == (lpc >> (OW + IW)));
        et = eh && (m_hist[li] != 0);
        eg = et ? m_tgt[li] : '0;
        ui = int'(upc[OW +: IW]);
        uh = m_vld[ui] && (m_tag[ui] == (upc >> (OW + IW)));
        up = uh && (m_hist[ui] != 0);
        em = uv && ((ut != up) || (ut && up && m_tgt[ui] != utg));
        if (uv) begin
            if (uh) begin
                if (ut) begin
                    m_hist[ui] = (m_hist[ui] == 3) ? 3 : m_hist[ui] + 1;
                    m_tgt[ui]  = utg;
                end else begin
                    m_hist[ui] = (m_hist[ui] == 0) ? 0 : m_hist[ui] - 1;
                end
            end else if (ut) begin
                m_vld[ui] = 1'b1; m_tag[ui] = upc >> (OW + IW);
                m_tgt[ui] = utg;  m_hist[ui] = 3;
            end
        end
        q_due.push_back(cyc + 1);
        q_val.push_back({eh, et, em, eg});
        q_req.push_back(req);
    endtask

    task automatic look(input logic [AW-1:0] pc, input string req);
        step(1'b1, pc, 1'b0, '0, 1'b0, '0, req);
    endtask

    task automatic resolve(input logic [AW-1:0] pc, input logic t,
                           input logic [AW-1:0] tg, input string req);
        step(1'b0, '0, 1'b1, pc, t, tg, req);
    endtask

    task automatic idle(input string req);
        step(1'b0, '0, 1'b0, '0, 1'b0, '0, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        lk_valid = 1'b0; upd_valid = 1'b0;
        while (q_due.size() != 0) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        model_clear();
        rst = 1'b0;
    endtask

    logic [AW+2:0] mon_exp, mon_act;
    string         mon_req;
    always @(negedge clk) begin
        if (!rst && q_due.size() > 0 && q_due[0] == cyc) begin
            void'(q_due.pop_front());
            mon_exp = q_val.pop_front();
            mon_req = q_req.pop_front();
            mon_act = {pred_hit, pred_taken, mispredict, pred_target};
            total++;
            if (mon_act !== mon_exp) begin
                bad++;
                $display("FAIL %s: actual hit=%0b taken=%0b mis=%0b target=%h expected hit=%0b taken=%0b mis=%0b target=%h",
                         mon_req, mon_act[AW+2], mon_act[AW+1], mon_act[AW], mon_act[AW-1:0],
                         mon_exp[AW+2], mon_exp[AW+1], mon_exp[AW], mon_exp[AW-1:0]);
            end
        end
    end

    localparam logic [AW-1:0] PC_A = 32'h0000_1048;
    localparam logic [AW-1:0] PC_B = 32'h0000_2048; // same index as PC_A
    localparam logic [AW-1:0] PC_C = 32'h0000_104C;
    localparam logic [AW-1:0] PC_D = 32'h0000_3010;

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        total++;
        if ({pred_hit, pred_taken, mispredict, pred_target} !== '0) begin
            bad++;
            $display("FAIL R1 reset state: actual hit=%0b taken=%0b mis=%0b target=%h expected all zero",
                     pred_hit, pred_taken, mispredict, pred_target);
        end

        look(PC_A, "R2 empty table miss");
        idle("R2 idle cycle");
        resolve(PC_A, 1'b0, 32'h500, "R4 not-taken miss");
        look(PC_A, "R4 no allocation on not-taken");
        resolve(PC_A, 1'b1, 32'h500, "R4 allocate on first taken, R8 miss counted not taken");
        look(PC_A, "R4 R5 allocated entry predicts taken");
        resolve(PC_A, 1'b0, 32'h500, "R8 direction wrong at history 3");
        look(PC_A, "R6 history 2 still taken");
        resolve(PC_A, 1'b0, 32'h500, "R6 down to 1");
        resolve(PC_A, 1'b0, 32'h500, "R6 down to 0");
        look(PC_A, "R5 history 0 predicts not taken");
        resolve(PC_A, 1'b0, 32'h500, "R6 low saturation no mispredict");
        resolve(PC_A, 1'b1, 32'h500, "R8 taken at history 0");
        look(PC_A, "R6 low saturation then up to 1");
        resolve(PC_A, 1'b1, 32'h500, "R6 up to 2");
        resolve(PC_A, 1'b1, 32'h500, "R6 up to 3");
        resolve(PC_A, 1'b1, 32'h500, "R6 high saturation");
        resolve(PC_A, 1'b0, 32'h500, "R6 down from saturated 3");
        look(PC_A, "R6 high saturation kept taken");
        resolve(PC_A, 1'b1, 32'h600, "R7 R8 new target mispredicts");
        look(PC_A, "R7 target overwritten");
        look(PC_B, "R3 alias tag miss");
        look(PC_C, "R3 neighbour index miss");
        resolve(PC_B, 1'b1, 32'h700, "R3 R4 alias replaces entry");
        look(PC_A, "R3 evicted address misses");
        look(PC_B, "R3 alias now hits");
        step(1'b1, PC_C, 1'b1, PC_C, 1'b1, 32'h900, "R9 same-cycle lookup sees old table");
        look(PC_C, "R9 update visible next cycle");
        step(1'b1, PC_B, 1'b1, PC_B, 1'b0, 32'h700, "R9 same-cycle lookup before training");
        look(PC_B, "R9 trained history 2 taken");

        resolve(PC_D, 1'b1, 32'hA00, "R10 warmup allocate");
        resolve(PC_D, 1'b0, 32'hA00, "R10 warmup 3 to 2");
        resolve(PC_D, 1'b0, 32'hA00, "R10 warmup 2 to 1");
        resolve(PC_D, 1'b0, 32'hA00, "R10 warmup 1 to 0");
        for (int k = 0; k < 6; k++) begin
            resolve(PC_D, 1'b1, 32'hA00, "R10 alternating taken mispredicted");
            resolve(PC_D, 1'b0, 32'hA00, "R10 alternating not-taken mispredicted");
        end
        idle("R8 no pulse without update");

        do_reset();
        look(PC_B, "R1 reset cleared entry");
        look(PC_C, "R1 reset cleared second entry");
        idle("R2 idle after reset");

        @(negedge clk);
        while (q_due.size() != 0) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual run still busy expected finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule